// File: doc/BRIEF.md
# Serial Register Port with Burst Access

This block is a serial slave that reaches a bank of eight 8-bit registers at addresses 10h to 17h. A host frames each access by pulling the active-low chip select low. It then clocks in a command byte followed by register data. Both are shifted least significant bit first. The command byte says whether the access reads or writes, which register it targets, and whether it is a burst.

A burst ignores the address field. It walks the whole bank from 10h to 17h in order, in either direction. The registers sit outside the block. The port drives an index, write data and a write strobe toward them, and takes the read data back from them in the same cycle.

The serial inputs are brought into the system clock domain through a synchronizer. Edges of the serial clock are detected there. The serial clock must therefore run well below the system clock.

Top module: `serial_regport`

## Requirements
- R1: The command byte is the first byte after chip select falls. Bit 0, shifted first, selects the direction (1 = read, 0 = write). Bits 6:1 carry the 6-bit register address. Bit 7 is the burst flag.
- R2: A single write to an address in 10h..17h raises `reg_we` for exactly one clock. This happens only after the eighth data bit is sampled, with `reg_sel` = address − 10h and `reg_wdata` = the byte assembled LSb first.
- R3: A single read presents the addressed register on `sdo` LSb first. Each bit changes after a falling SCLK edge and is held across the following rising edge, where the host samples it.
- R4: A write to an address outside 10h..17h raises no strobe. A read of such an address returns 00h.
- R5: A burst read streams the registers at 10h through 17h in that order, whatever the address field holds. After 17h has been sent, `sdo_oe` stays low for the rest of the frame.
- R6: A burst write stores eight consecutive data bytes to indices 0..7 in order. Any data bytes after the eighth raise no strobe.
- R7: While chip select is high, `sdo_oe` is low and the port is idle. A rising chip select abandons the transfer, and a data byte cut short by it is discarded without a strobe.
- R8: `sdo_oe` is high only during the data phase of a read. It is low while the command byte is shifted and throughout any write.
- R9: After reset, `sdo_oe` and `reg_we` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low; frames each transfer |
| sclk | input | 1 | Serial clock from the host; idles low |
| sdi | input | 1 | Serial data in, sampled on SCLK rising edges |
| sdo | output | 1 | Serial data out; 0 whenever `sdo_oe` is low |
| sdo_oe | output | 1 | Output enable for the SDO pad buffer; low means high-impedance |
| reg_sel | output | 3 | Index of the register being accessed (address − 10h) |
| reg_wdata | output | 8 | Byte to store into the selected register |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Contents of the register named by `reg_sel` |

## Verification
The bench builds the port with its defaults: a two-stage synchronizer, a base of 10h and eight registers. It runs the serial clock at sixteen system clocks per bit. These values put both range edges within reach with plain addresses: 0Fh and 18h sit just outside, and 10h and 17h bound a burst. The slow serial clock leaves room for the read data load between bytes. The bench keeps its own copy of the register contents and compares every strobe against a queue of expected writes on every clock. This covers bursts that start from unrelated address fields, extra bytes past the end of a burst, and frames cut mid-byte.

// File: rtl/serport_pkg.sv
package serport_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_CMD,
    PH_DATA,
    PH_DONE
  } phase_t;

  // command byte layout; bit 0 is shifted first
  typedef struct packed {
    logic       burst;
    logic [5:0] addr;
    logic       rd;
  } cmd_t;

  function automatic logic addr_hit(input logic [5:0] a, input logic [5:0] base,
                                    input int unsigned n);
    logic [6:0] d;
    d = {1'b0, a} - {1'b0, base};
    return (a >= base) && ({25'd0, d} < n);
  endfunction

  function automatic logic [5:0] last_addr(input logic [5:0] base, input int unsigned n);
    return base + 6'(n - 1);
  endfunction

endpackage

// File: rtl/serport_sync.sv
module serport_sync #(
  parameter int             WIDTH   = 3,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int CHAIN_W = STAGES * WIDTH;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[CHAIN_W-WIDTH-1:0], d};
  end

  assign q = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/serport_rx.sv
module serport_rx #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              sdi,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte
);
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic              done_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !cs_act) begin
      cnt    <= '0;
      sh     <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (sclk_rise) begin
        sh     <= {sdi, sh[BYTE_W-1:1]};
        cnt    <= cnt + 1'b1;
        done_q <= (cnt == CNT_W'(BYTE_W - 1));
      end
    end
  end

  assign byte_done = done_q;
  assign rx_byte   = sh;

  // R1
  byte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);
endmodule

// File: rtl/serport_seq.sv
module serport_seq
  import serport_pkg::*;
#(
  parameter logic [5:0] BASE_ADDR = 6'h10,
  parameter int         NUM_REGS  = 8,
  localparam int        SELW      = $clog2(NUM_REGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_act,
  input  logic            sclk_fall,
  input  logic            byte_done,
  input  logic [7:0]      rx_byte,
  input  logic [7:0]      reg_rdata,
  output logic            sdo,
  output logic            sdo_oe,
  output logic [SELW-1:0] reg_sel,
  output logic [7:0]      reg_wdata,
  output logic            reg_we
);
  localparam logic [5:0] LAST = last_addr(BASE_ADDR, NUM_REGS);

  phase_t     ph;
  logic       rd_q, burst_q, load_q, sdo_q;
  logic [5:0] ptr, off;
  logic [7:0] tx_sh;
  cmd_t       cmd;

  assign cmd = cmd_t'(rx_byte);

  // named events used by the logic and the assertions
  wire ptr_hit  = addr_hit(ptr, BASE_ADDR, NUM_REGS);
  wire ptr_last = (ptr == LAST);
  wire cmd_evt  = byte_done && (ph == PH_CMD);
  wire data_evt = byte_done && (ph == PH_DATA);
  wire advance  = data_evt && burst_q && !ptr_last;

  always_ff @(posedge clk) begin
    if (!rst_n || !cs_act) begin
      ph      <= PH_IDLE;
      rd_q    <= 1'b0;
      burst_q <= 1'b0;
      load_q  <= 1'b0;
      ptr     <= '0;
      tx_sh   <= '0;
      sdo_q   <= 1'b0;
    end else begin
      load_q <= 1'b0;
      unique case (ph)
        PH_IDLE: ph <= PH_CMD;
        PH_CMD: if (cmd_evt) begin
          ph      <= PH_DATA;
          rd_q    <= cmd.rd;
          burst_q <= cmd.burst;
          ptr     <= cmd.burst ? BASE_ADDR : cmd.addr;
          load_q  <= cmd.rd;
        end
        PH_DATA: begin
          if (data_evt) begin
            if (advance) begin
              ptr    <= ptr + 6'd1;
              load_q <= rd_q;
            end else begin
              ph <= PH_DONE;
            end
          end else if (load_q) begin
            tx_sh <= ptr_hit ? reg_rdata : 8'h00;
          end else if (rd_q && sclk_fall) begin
            sdo_q <= tx_sh[0];
            tx_sh <= {1'b0, tx_sh[7:1]};
          end
        end
        default: ;
      endcase
    end
  end

  assign off       = ptr - BASE_ADDR;
  assign reg_sel   = off[SELW-1:0];
  assign reg_wdata = rx_byte;
  assign reg_we    = data_evt && !rd_q && ptr_hit;
  assign sdo_oe    = (ph == PH_DATA) && rd_q;
  assign sdo       = sdo_oe & sdo_q;

  // R7
  idle_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !sdo_oe);
  // R8
  wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !sdo_oe);
  // R2
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  // R5
  burst_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DATA && burst_q) |-> ptr_hit);
  // R6
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && burst_q && !ptr_last) |=> (reg_sel == $past(reg_sel) + 1'b1));
  // R3
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && !$past(sclk_fall)) |-> $stable(sdo));
endmodule

// File: rtl/serial_regport.sv
module serial_regport #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] BASE_ADDR   = 6'h10,
  parameter int         NUM_REGS    = 8,
  localparam int        SELW        = $clog2(NUM_REGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            sclk,
  input  logic            sdi,
  output logic            sdo,
  output logic            sdo_oe,
  output logic [SELW-1:0] reg_sel,
  output logic [7:0]      reg_wdata,
  output logic            reg_we,
  input  logic [7:0]      reg_rdata
);
  logic [2:0] pins_s;
  logic       sclk_d;
  logic       byte_done;
  logic [7:0] rx_byte;

  serport_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdi}), .q(pins_s)
  );

  wire cs_act = ~pins_s[2];
  wire sclk_s = pins_s[1];
  wire sdi_s  = pins_s[0];

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  wire sclk_rise = sclk_s & ~sclk_d;
  wire sclk_fall = ~sclk_s & sclk_d;

  serport_rx #(.BYTE_W(8)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_rise(sclk_rise),
    .sdi(sdi_s), .byte_done(byte_done), .rx_byte(rx_byte)
  );

  serport_seq #(.BASE_ADDR(BASE_ADDR), .NUM_REGS(NUM_REGS)) u_seq (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_fall(sclk_fall),
    .byte_done(byte_done), .rx_byte(rx_byte), .reg_rdata(reg_rdata),
    .sdo(sdo), .sdo_oe(sdo_oe), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_we(reg_we)
  );
endmodule

// File: tb/tb_serial_regport.sv
module tb_serial_regport;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  wire       sdo, sdo_oe, reg_we;
  wire [2:0] reg_sel;
  wire [7:0] reg_wdata;
  logic [7:0] reg_rdata;

  logic [7:0]  bank [8];
  logic [7:0]  mdl  [8];
  logic [10:0] exp_q [$];
  int n_run = 0, n_fail = 0, cs_hi = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  serial_regport dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'(8'h31 * i + 5);
  endfunction

  function automatic logic [7:0] mk_cmd(input bit burst, input logic [5:0] a, input bit rd);
    return {burst, a, rd};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // register bank living behind the port
  always_comb reg_rdata = bank[reg_sel];

  // per-clock comparison against the expected write stream
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) bank[i] <= init_val(i);
    end else if (reg_we) begin
      if (exp_q.size() == 0) begin
        chk(0, "R4/R6/R7", "unexpected strobe", int'({reg_sel, reg_wdata}), 0);
      end else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        chk({reg_sel, reg_wdata} == e, "R2/R6", "strobe sel/data",
            int'({reg_sel, reg_wdata}), int'(e));
      end
      bank[reg_sel] <= reg_wdata;
    end
  end

  // R7: output enable must stay low while chip select is high
  always @(posedge clk) begin
    cs_hi <= cs_n ? cs_hi + 1 : 0;
    if (rst_n && cs_hi > 4 && sdo_oe) chk(0, "R7", "oe with cs high", 1, 0);
  end

  task automatic expect_wr(input int idx, input logic [7:0] d);
    exp_q.push_back({3'(idx), d});
    mdl[idx] = d;
  endtask

  task automatic open_cs();
    @(negedge clk); cs_n = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic close_cs();
    sclk = 1'b0;
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic shift_byte(input logic [7:0] b, input int nbits,
                            output logic [7:0] got, output int oe_cnt);
    got = 8'h00; oe_cnt = 0;
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0; sdi = b[i];
      repeat (8) @(negedge clk);
      got[i] = sdo;
      if (sdo_oe) oe_cnt++;
      sclk = 1'b1;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic single_read(input logic [5:0] a, input logic [7:0] exp, input string req);
    logic [7:0] g; int oc;
    open_cs();
    shift_byte(mk_cmd(0, a, 1), 8, g, oc);
    chk(oc == 0, "R8", "oe during command", oc, 0);
    shift_byte(8'h00, 8, g, oc);
    chk(g == exp, req, "read data", g, exp);
    close_cs();
  endtask

  task automatic single_write(input logic [5:0] a, input logic [7:0] d);
    logic [7:0] g; int oc;
    open_cs();
    shift_byte(mk_cmd(0, a, 0), 8, g, oc);
    shift_byte(d, 8, g, oc);
    chk(oc == 0, "R8", "oe during write data", oc, 0);
    close_cs();
  endtask

  initial begin
    logic [7:0] g; int oc;
    for (int i = 0; i < 8; i++) mdl[i] = init_val(i);
    repeat (4) @(negedge clk);
    // R9: reset state
    chk(sdo_oe == 0, "R9", "oe in reset", sdo_oe, 0);
    chk(reg_we == 0, "R9", "we in reset", reg_we, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 R3: single read of 12h
    single_read(6'h12, mdl[2], "R1/R3");
    open_cs();
    shift_byte(mk_cmd(0, 6'h17, 1), 8, g, oc);
    shift_byte(8'h00, 8, g, oc);
    chk(oc == 8, "R3", "oe bits during read", oc, 8);
    chk(g == mdl[7], "R3", "read 17h", g, mdl[7]);
    close_cs();

    // R2: single writes, then read back
    expect_wr(5, 8'h5A);
    single_write(6'h15, 8'h5A);
    chk(exp_q.size() == 0, "R2", "pending writes", exp_q.size(), 0);
    single_read(6'h15, 8'h5A, "R2");
    expect_wr(0, 8'h81);
    single_write(6'h10, 8'h81);
    chk(exp_q.size() == 0, "R2", "pending writes 10h", exp_q.size(), 0);

    // R4: out-of-range
    single_write(6'h05, 8'h77);
    single_write(6'h0F, 8'h66);
    single_write(6'h18, 8'h55);
    chk(exp_q.size() == 0, "R4", "pending after stray writes", exp_q.size(), 0);
    single_read(6'h05, 8'h00, "R4");
    single_read(6'h18, 8'h00, "R4");
    single_read(6'h3F, 8'h00, "R4");

    // R6: burst write, address field 2Ah, two extra bytes
    for (int i = 0; i < 8; i++) expect_wr(i, 8'(8'hC0 + i));
    open_cs();
    shift_byte(mk_cmd(1, 6'h2A, 0), 8, g, oc);
    for (int i = 0; i < 10; i++) begin
      shift_byte(8'(8'hC0 + i), 8, g, oc);
      chk(oc == 0, "R8", "oe during burst write", oc, 0);
    end
    close_cs();
    chk(exp_q.size() == 0, "R6", "burst writes done", exp_q.size(), 0);

    // R5: burst read, address field 00h, then one extra byte
    open_cs();
    shift_byte(mk_cmd(1, 6'h00, 1), 8, g, oc);
    for (int i = 0; i < 8; i++) begin
      shift_byte(8'h00, 8, g, oc);
      chk(g == mdl[i], "R5", "burst read byte", g, mdl[i]);
    end
    shift_byte(8'h00, 8, g, oc);
    chk(oc == 0, "R5", "oe after 17h", oc, 0);
    close_cs();

    // R7: partial write byte discarded
    open_cs();
    shift_byte(mk_cmd(0, 6'h11, 0), 8, g, oc);
    shift_byte(8'hEE, 5, g, oc);
    close_cs();
    chk(exp_q.size() == 0, "R7", "no strobe after cut", exp_q.size(), 0);
    single_read(6'h11, mdl[1], "R7");

    // R7: burst read abandoned, next frame starts clean
    open_cs();
    shift_byte(mk_cmd(1, 6'h00, 1), 8, g, oc);
    for (int i = 0; i < 3; i++) shift_byte(8'h00, 8, g, oc);
    shift_byte(8'h00, 3, g, oc);
    close_cs();
    chk(sdo_oe == 0, "R7", "oe after abort", sdo_oe, 0);
    single_read(6'h16, mdl[6], "R7");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", "run did not finish", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule